// File: doc/BRIEF.md
# Processor Reset and Bus-Request Strap Sequencer

This block produces the active-low reset for a processor on the host bus clock, and it drives a bus-request configuration strap around the edge where that reset is released. The platform reset input is active low and asynchronous. It passes through a two-stage synchronizer. While it is active the processor reset is held. After it is released, a programmable delay keeps the processor in reset; the default is 100000 cycles, about 1 ms at 100 MHz. The reset is then released.

The strap can be driven or left floating, so it leaves the block as an output enable plus a value. It is driven low for the whole time the processor is in reset. This gives the processor a stable low level for the setup time before the edge on which it samples the strap. The strap stays driven for a fixed number of clocks after that edge, then the driver turns off. If the platform reset is asserted again at any point, the processor goes back into reset and the whole sequence starts over.

Top module: `cpu_rst_seq`

## Requirements
- R1: Once `plat_rst_n` is low, `cpu_rst_n` is low no later than 3 clocks later (2 synchronizer stages plus the state register). It stays low for as long as the synchronized platform reset is active.
- R2: `plat_rst_n` rises and then stays high. Exactly `DELAY_CYCLES + 4` clocks later, `cpu_rst_n` rises. The 4 clocks are 2 synchronizer stages, 1 state entry and 1 release cycle.
- R3: Whenever `cpu_rst_n` is 0, the strap is driven low: `strap_oe` = 1 and `strap_val` = 0.
- R4: `strap_oe` = 1 and `strap_val` = 0 for at least 4 consecutive clocks before every rising edge of `cpu_rst_n`. `DELAY_CYCLES` below 3 is rejected at elaboration.
- R5: After `cpu_rst_n` rises, `strap_oe` stays 1 with `strap_val` = 0 for exactly `HOLD_CYCLES` clocks, then drops to 0.
- R6: `HOLD_CYCLES` defaults to 4, and elaboration rejects any value outside 2 to 20. Both bounds, 2 and 20, produce the behaviour in R5.
- R7: After the hold window, `strap_oe` = 0 and `cpu_rst_n` = 1 persist until the platform reset is asserted again.
- R8: The platform reset may be asserted again during the delay count. `cpu_rst_n` then stays low, and the full `DELAY_CYCLES + 4` count restarts from the new release.
- R9: The platform reset may be asserted again after the strap has floated. Within 3 clocks, `cpu_rst_n` returns to 0 and `strap_oe` returns to 1.
- R10: The synchronous active-high `rst` makes the next clock show `cpu_rst_n` = 0, `strap_oe` = 1 and `strap_val` = 0. It also loads the synchronizer as if the platform reset were active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host bus clock |
| rst | input | 1 | Synchronous active-high block reset |
| plat_rst_n | input | 1 | Asynchronous active-low platform reset |
| cpu_rst_n | output | 1 | Active-low processor reset |
| strap_oe | output | 1 | Bus-request strap driver enable (0 = high impedance) |
| strap_val | output | 1 | Bus-request strap value while enabled |

## Verification
The assertions assume that a low pulse on `plat_rst_n` lasts at least one full clock, so that the synchronizer captures it. They also assume that `rst` is asserted from time zero, so the state register is known before the first check. The bench drives `plat_rst_n` only at falling clock edges and holds every reset pulse for two clocks. This keeps each restart seen by the design equal to the restart the bench computes. Glitch offsets are swept only across the delay count, and each pulse is timed to land before the release cycle.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;

    localparam int SYNC_STAGES = 2;
    localparam int SETUP_MIN   = 4;
    localparam int HOLD_MIN    = 2;
    localparam int HOLD_MAX    = 20;

    typedef enum logic [2:0] {
        IN_RESET    = 3'd0,
        DELAY_COUNT = 3'd1,
        RELEASE     = 3'd2,
        HOLD_STRAP  = 3'd3,
        DONE        = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic cpu_rst_n;
        logic strap_oe;
        logic strap_val;
    } seq_pins_t;

    function automatic bit hold_in_range(int h);
        return (h >= HOLD_MIN) && (h <= HOLD_MAX);
    endfunction

    function automatic seq_pins_t decode_pins(seq_state_e s);
        seq_pins_t p;
        p.strap_val = 1'b0;
        case (s)
            HOLD_STRAP: begin p.cpu_rst_n = 1'b1; p.strap_oe = 1'b1; end
            DONE:       begin p.cpu_rst_n = 1'b1; p.strap_oe = 1'b0; end
            default:    begin p.cpu_rst_n = 1'b0; p.strap_oe = 1'b1; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cpu_rst_sync.sv
module cpu_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic rst_act
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= 1'b0;
                end else if (i == 0) begin
                    chain[i] <= async_n;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign rst_act = ~chain[STAGES-1];
endmodule

// File: rtl/cpu_rst_fsm.sv
module cpu_rst_fsm
    import cpu_rst_pkg::*;
#(
    parameter int DELAY_CYCLES = 100000,
    parameter int HOLD_CYCLES  = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rst_act,
    output seq_pins_t pins
);
    localparam int LIMIT = (DELAY_CYCLES > HOLD_CYCLES) ? DELAY_CYCLES : HOLD_CYCLES;
    localparam int CNT_W = $clog2(LIMIT + 1);

    generate
        if (!hold_in_range(HOLD_CYCLES)) begin : g_bad_hold
            $error("HOLD_CYCLES outside 2..20");
        end
        if (DELAY_CYCLES < SETUP_MIN - 1) begin : g_bad_delay
            $error("DELAY_CYCLES too short for strap setup");
        end
    endgenerate

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            IN_RESET:    if (!rst_act) state_d = DELAY_COUNT;
            DELAY_COUNT: if (cnt_q == CNT_W'(DELAY_CYCLES - 1)) state_d = RELEASE;
            RELEASE:     state_d = HOLD_STRAP;
            HOLD_STRAP:  if (cnt_q == CNT_W'(HOLD_CYCLES - 1)) state_d = DONE;
            DONE:        state_d = DONE;
            default:     state_d = IN_RESET;
        endcase
        if (rst_act) state_d = IN_RESET;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IN_RESET;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (state_q == DELAY_COUNT || state_q == HOLD_STRAP) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pins = decode_pins(state_q);
endmodule

// File: rtl/cpu_rst_seq.sv
module cpu_rst_seq
    import cpu_rst_pkg::*;
#(
    parameter int DELAY_CYCLES = 100000,
    parameter int HOLD_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic plat_rst_n,
    output logic cpu_rst_n,
    output logic strap_oe,
    output logic strap_val
);
    logic      rst_act;
    seq_pins_t pins;

    cpu_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (plat_rst_n),
        .rst_act (rst_act)
    );

    cpu_rst_fsm #(
        .DELAY_CYCLES (DELAY_CYCLES),
        .HOLD_CYCLES  (HOLD_CYCLES)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .rst_act (rst_act),
        .pins    (pins)
    );

    assign cpu_rst_n = pins.cpu_rst_n;
    assign strap_oe  = pins.strap_oe;
    assign strap_val = pins.strap_val;
endmodule

// File: rtl/cpu_rst_seq_chk.sv
module cpu_rst_seq_chk
    import cpu_rst_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic sync_act,
    input logic cpu_rst_n,
    input logic strap_oe,
    input logic strap_val
);
    logic [5:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (cpu_rst_n && strap_oe) begin
            if (hold_cnt != 6'h3f) hold_cnt <= hold_cnt + 1'b1;
        end else begin
            hold_cnt <= '0;
        end
    end

    // R1
    reset_follows_chk: assert property (@(posedge clk) disable iff (rst)
        sync_act |=> !cpu_rst_n);

    // R3
    strap_low_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_rst_n |-> (strap_oe && !strap_val));

    // R4
    strap_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_rst_n) |-> ($past(strap_oe, 1) && $past(strap_oe, 2) &&
                              $past(strap_oe, 3) && $past(strap_oe, 4) &&
                              !$past(strap_val, 1) && !$past(strap_val, 4)));

    // R5
    strap_hold_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(strap_oe) && cpu_rst_n) |-> (hold_cnt >= 6'(HOLD_MIN) && hold_cnt <= 6'(HOLD_MAX)));

    // R5
    strap_hold_max_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rst_n && strap_oe) |-> (hold_cnt < 6'(HOLD_MAX)));

    // R7
    float_only_running_chk: assert property (@(posedge clk) disable iff (rst)
        !strap_oe |-> cpu_rst_n);
endmodule

bind cpu_rst_seq cpu_rst_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync_act  (rst_act),
    .cpu_rst_n (cpu_rst_n),
    .strap_oe  (strap_oe),
    .strap_val (strap_val)
);

// File: tb/cpu_rst_seq_test.sv
module cpu_rst_seq_test;
    localparam int D  = 12;
    localparam int NI = 3;
    localparam int HOLDS [NI] = '{2, 4, 20};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic plat_rst_n = 1'b0;
    logic cpu [NI];
    logic oe  [NI];
    logic val [NI];

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cpu_rst_seq #(.DELAY_CYCLES(D), .HOLD_CYCLES(4)) uut (
        .clk(clk), .rst(rst), .plat_rst_n(plat_rst_n),
        .cpu_rst_n(cpu[1]), .strap_oe(oe[1]), .strap_val(val[1]));

    cpu_rst_seq #(.DELAY_CYCLES(D), .HOLD_CYCLES(2)) uut_h2 (
        .clk(clk), .rst(rst), .plat_rst_n(plat_rst_n),
        .cpu_rst_n(cpu[0]), .strap_oe(oe[0]), .strap_val(val[0]));

    cpu_rst_seq #(.DELAY_CYCLES(D), .HOLD_CYCLES(20)) uut_h20 (
        .clk(clk), .rst(rst), .plat_rst_n(plat_rst_n),
        .cpu_rst_n(cpu[2]), .strap_oe(oe[2]), .strap_val(val[2]));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called just after the release event at a falling edge; counts clocks
    // until each instance raises its reset and then floats its strap.
    task automatic measure(input string req);
        int rise_e [NI];
        int off_e  [NI];
        int bad    [NI];
        for (int i = 0; i < NI; i++) begin rise_e[i] = -1; off_e[i] = -1; bad[i] = 0; end
        for (int e = 1; e <= D + 30; e++) begin
            @(negedge clk);
            for (int i = 0; i < NI; i++) begin
                if (rise_e[i] < 0 && cpu[i]) rise_e[i] = e;
                if (off_e[i] < 0 && !oe[i]) off_e[i] = e;
                if (!cpu[i] && !(oe[i] && !val[i])) bad[i]++;
                if (cpu[i] && oe[i] && val[i]) bad[i]++;
            end
        end
        for (int i = 0; i < NI; i++) begin
            check(rise_e[i] == D + 4, {req, " R2 rise"}, rise_e[i], D + 4);
            check(off_e[i] - rise_e[i] == HOLDS[i], "R5/R6 hold", off_e[i] - rise_e[i], HOLDS[i]);
            check(bad[i] == 0, "R3/R4 strap driven low before rise", bad[i], 0);
            check(cpu[i] && !oe[i], "R7 floated and running", {cpu[i], oe[i]}, 2);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        for (int i = 0; i < NI; i++)
            check(!cpu[i] && oe[i] && !val[i], "R10 reset state", {cpu[i], oe[i], val[i]}, 3'b010);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < NI; i++)
            check(!cpu[i] && oe[i], "R1 held in platform reset", cpu[i], 0);

        // main release
        plat_rst_n = 1'b1;
        measure("R2 first");
        repeat (10) @(negedge clk);
        for (int i = 0; i < NI; i++)
            check(cpu[i] && !oe[i], "R7 stays floated", {cpu[i], oe[i]}, 2);

        // reassert after completion
        begin
            int n = -1;
            plat_rst_n = 1'b0;
            for (int e = 1; e <= 6; e++) begin
                @(negedge clk);
                if (n < 0 && !cpu[1] && oe[1]) n = e;
            end
            check(n == 3, "R9 reassert latency", n, 3);
            check(n == 3, "R1 assert within 3", n, 3);
        end

        // glitch sweep during the delay count
        for (int off = 0; off <= D - 4; off++) begin
            int hi = 0;
            plat_rst_n = 1'b1;
            repeat (off + 3) begin
                @(negedge clk);
                if (cpu[1]) hi++;
            end
            plat_rst_n = 1'b0;
            repeat (2) begin
                @(negedge clk);
                if (cpu[1]) hi++;
            end
            plat_rst_n = 1'b1;
            check(hi == 0, "R8 stays in reset on glitch", hi, 0);
            measure("R8 restart");
            plat_rst_n = 1'b0;
            repeat (4) @(negedge clk);
        end

        // block reset while running: next cycle in reset, then full sequence
        plat_rst_n = 1'b1;
        measure("R2 pre-rst");
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NI; i++)
            check(!cpu[i] && oe[i] && !val[i], "R10 rst mid-run", {cpu[i], oe[i], val[i]}, 3'b010);
        rst = 1'b0;
        measure("R10 after rst");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule